// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block watches the clock and data lines of an SMBus interface and flags two bus conditions. The first is a clock line held low for too long: a programmable counter runs on the system clock while SCL is low, is reloaded whenever SCL is high, and emits a one-cycle timeout pulse each time it reaches its terminal value. The second is an idle bus: while both SCL and SDA are high, a small counter advances on each clock-source tick. When the lines have stayed high for more than ten ticks, the monitor treats the bus as released.

A bus-free detection is reported the same way a STOP condition would be. It sets a sticky stop flag and raises an interrupt request, and both stay up until software clears the flag. Each detector has its own enable bit. Recovering the bus after a clock-low timeout is left to the surrounding interface.

Both line inputs are asynchronous and pass through a two-flop synchronizer before any counter uses them. The clock-source tick is a one-cycle strobe that is already in the system clock domain.

Top module: `smbus_timeout_mon`

## Requirements
- R1: SCL and SDA pass through two synchronizer flops. When SCL falls with low_reload=r and low_terminal=r+N-1, the first timeout pulse is high in the cycle after the (N+2)-th rising clock edge following the fall, and not before.
- R2: While the synchronized SCL is high, the clock-low counter is reloaded from low_reload. Any high interval restarts the count, so a pulse requires N=low_terminal-low_reload+1 consecutive low cycles.
- R3: low_to_pulse is one cycle wide, and the counter reloads on its own after each pulse. A low interval of L cycles therefore yields exactly floor(L/N) pulses.
- R4: With low_to_en=0, low_to_pulse stays 0 whatever SCL does.
- R5: With free_to_en=1 and both lines high, the 11th src_tick of the interval (more than FREE_TICKS=10) triggers a bus-free detection. Ten ticks trigger nothing.
- R6: A bus-free detection fires at most once per idle interval. After the flag is cleared, further ticks in the same interval do not set it again.
- R7: A low level on either SCL or SDA clears the tick count, and ticks that arrive while a line is low are not counted.
- R8: With free_to_en=0, no bus-free detection occurs and stop_flag stays 0.
- R9: A bus-free detection sets stop_flag, which then stays 1 until stop_clr=1. If a detection and stop_clr occur in the same cycle, the flag is set.
- R10: irq equals stop_flag in every cycle.
- R11: During and straight after reset, low_to_pulse, stop_flag and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_in | input | 1 | SCL line level, asynchronous |
| sda_in | input | 1 | SDA line level, asynchronous |
| src_tick | input | 1 | One-cycle clock-source strobe |
| low_to_en | input | 1 | Enables the clock-low timeout |
| free_to_en | input | 1 | Enables bus-free detection |
| low_reload | input | CNT_W | Start value of the clock-low counter |
| low_terminal | input | CNT_W | Counter value that signals a timeout |
| stop_clr | input | 1 | Clears the stop flag |
| low_to_pulse | output | 1 | One-cycle clock-low timeout pulse |
| stop_flag | output | 1 | Sticky stop / bus-free flag |
| irq | output | 1 | Interrupt request, follows stop_flag |

## Verification
The assertions check four things on every cycle:
- a disabled clock-low timer stays quiet;
- a timeout pulse is always preceded by a synchronized low on SCL;
- a high SCL reloads the counter;
- a bus-free detection only fires with both lines high, always lands in the stop flag, and the flag holds until a clear.

Other behaviour can only be shown by the bench's scenarios:
- exact pulse counts over low intervals of random length;
- the synchronizer latency;
- the eleventh-tick threshold;
- the single firing per interval;
- set priority over clear.

// File: rtl/smto_pkg.sv
// Package: shared defaults for the SMBus timeout monitor.
// Assumes: nothing; holds constants only.
package smto_pkg;
    localparam int SMTO_CNT_W       = 16;  // clock-low counter width
    localparam int SMTO_FREE_TICKS  = 10;  // idle ticks that must be exceeded
    localparam int SMTO_SYNC_STAGES = 2;   // synchronizer depth
endpackage

// File: rtl/smto_sync.sv
// Module: multi-lane flop synchronizer for asynchronous line levels.
// Assumes: lines idle high, so every stage resets to 1.
module smto_sync #(
    parameter int LANES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] d_async,
    output logic [LANES-1:0] q_sync
);
    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [STAGES-1:0] chain;

        // Shift the lane level through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d_async[g]};
        end

        assign q_sync[g] = chain[LAST];
    end
endmodule

// File: rtl/smto_low_timer.sv
// Module: clock-low timeout counter. Counts system clocks while SCL is low,
// reloads while SCL is high or disabled, and pulses on reaching terminal.
// Assumes: terminal >= reload; scl_s already synchronized.
module smto_low_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             scl_s,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] terminal,
    output logic             pulse
);
    logic [CNT_W-1:0] cnt;

    // Count low time, reload on high or disable, auto-reload at terminal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else if (en && !scl_s) begin
            if (cnt == terminal) begin
                cnt   <= reload;
                pulse <= 1'b1;
            end else begin
                cnt   <= cnt + 1'b1;
                pulse <= 1'b0;
            end
        end else begin
            cnt   <= reload;
            pulse <= 1'b0;
        end
    end

    AST_LOW_DIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pulse);                                      // R4
    AST_LOW_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(!scl_s));                             // R2
    AST_LOW_RELOAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (en && scl_s) |=> (cnt == $past(reload)));            // R2
endmodule

// File: rtl/smto_free_timer.sv
// Module: bus-free detector. Counts source ticks while both lines are high
// and fires once when the count exceeds LIMIT within one idle interval.
// Assumes: tick is a one-cycle strobe in the clk domain; lines synchronized.
module smto_free_timer #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic scl_s,
    input  logic sda_s,
    output logic fire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic          idle;
    logic          fired;
    logic [CW-1:0] cnt;

    assign idle = scl_s && sda_s;
    assign fire = en && idle && tick && !fired && (cnt == LIM);

    // Advance on ticks while idle; clear on any low line or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !idle) begin
            cnt   <= '0;
            fired <= 1'b0;
        end else if (tick && !fired) begin
            if (cnt == LIM) fired <= 1'b1;
            else            cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/smto_stop_flag.sv
// Module: sticky stop flag; set has priority over software clear.
// Assumes: set and clr are single-cycle or level strobes in clk domain.
module smto_stop_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the flag until cleared; a simultaneous set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);                             // R9
endmodule

// File: rtl/smbus_timeout_mon.sv
// Module: SMBus timeout monitor top. Synchronizes the lines, runs the
// clock-low timer and the bus-free detector, and keeps the stop flag.
// Assumes: software clears stop_flag via stop_clr; recovery is external.
module smbus_timeout_mon
    import smto_pkg::*;
#(
    parameter int CNT_W      = SMTO_CNT_W,
    parameter int FREE_TICKS = SMTO_FREE_TICKS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             src_tick,
    input  logic             low_to_en,
    input  logic             free_to_en,
    input  logic [CNT_W-1:0] low_reload,
    input  logic [CNT_W-1:0] low_terminal,
    input  logic             stop_clr,
    output logic             low_to_pulse,
    output logic             stop_flag,
    output logic             irq
);
    logic [1:0] lines_s;
    logic       scl_s;
    logic       sda_s;
    logic       free_fire;

    smto_sync #(.LANES(2), .STAGES(SMTO_SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({sda_in, scl_in}), .q_sync(lines_s)
    );

    assign scl_s = lines_s[0];
    assign sda_s = lines_s[1];

    smto_low_timer #(.CNT_W(CNT_W)) u_low (
        .clk(clk), .rst_n(rst_n), .en(low_to_en), .scl_s(scl_s),
        .reload(low_reload), .terminal(low_terminal), .pulse(low_to_pulse)
    );

    smto_free_timer #(.LIMIT(FREE_TICKS)) u_free (
        .clk(clk), .rst_n(rst_n), .en(free_to_en), .tick(src_tick),
        .scl_s(scl_s), .sda_s(sda_s), .fire(free_fire)
    );

    smto_stop_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set(free_fire), .clr(stop_clr),
        .flag(stop_flag)
    );

    assign irq = stop_flag;

    AST_FREE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        free_fire |-> (scl_s && sda_s));                      // R7
    AST_FREE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        free_fire |=> stop_flag);                             // R9
endmodule

// File: tb/smbus_timeout_mon_bench.sv
module smbus_timeout_mon_bench;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n, scl_in, sda_in, src_tick, low_to_en, free_to_en, stop_clr;
    logic [W-1:0] low_reload, low_terminal;
    logic low_to_pulse, stop_flag, irq;

    int checks = 0;
    int errors = 0;
    int pulse_cnt = 0;

    always #4 clk = ~clk;

    smbus_timeout_mon u_smbus_timeout_mon (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .src_tick(src_tick), .low_to_en(low_to_en), .free_to_en(free_to_en),
        .low_reload(low_reload), .low_terminal(low_terminal),
        .stop_clr(stop_clr), .low_to_pulse(low_to_pulse),
        .stop_flag(stop_flag), .irq(irq)
    );

    always @(negedge clk) if (low_to_pulse) pulse_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_low_pulses(input int l, input int n, input bit en);
        return en ? (l / n) : 0;
    endfunction

    function automatic bit exp_free(input int t, input bit en, input bit idle);
        return en && idle && (t > 10);
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            src_tick = 1'b1; cyc(1);
            src_tick = 1'b0; cyc(2);
        end
    endtask

    task automatic run_low(input int n, input int l, input bit en);
        int r;
        r = $urandom_range(0, 1000);
        low_to_en = en; scl_in = 1'b1;
        low_reload = W'(r); low_terminal = W'(r + n - 1);
        cyc(4);
        pulse_cnt = 0;
        scl_in = 1'b0; cyc(l);
        scl_in = 1'b1; cyc(5);
        chk(pulse_cnt == exp_low_pulses(l, n, en), en ? "R3" : "R4",
            pulse_cnt, exp_low_pulses(l, n, en));
    endtask

    task automatic run_free(input int t, input bit en, input int which_low);
        bit e;
        free_to_en = en;
        scl_in = (which_low != 1); sda_in = (which_low != 2);
        cyc(4);
        tick_n(t);
        cyc(3);
        e = exp_free(t, en, which_low == 0);
        chk(stop_flag == e, en ? ((which_low == 0) ? "R5" : "R7") : "R8",
            int'(stop_flag), int'(e));
        chk(irq == stop_flag, "R10", int'(irq), int'(stop_flag));
        stop_clr = 1'b1; cyc(1); stop_clr = 1'b0;
        scl_in = 1'b0; cyc(4); scl_in = 1'b1;
        chk(stop_flag == 1'b0, "R9", int'(stop_flag), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; scl_in = 1'b1; sda_in = 1'b1; src_tick = 1'b0;
        low_to_en = 1'b0; free_to_en = 1'b0; stop_clr = 1'b0;
        low_reload = '0; low_terminal = W'(4);
        cyc(3);
        chk(!low_to_pulse && !stop_flag && !irq, "R11",
            int'({low_to_pulse, stop_flag, irq}), 0);
        rst_n = 1'b1; cyc(1);
        chk(!low_to_pulse && !stop_flag && !irq, "R11",
            int'({low_to_pulse, stop_flag, irq}), 0);

        // R1: exact latency through synchronizer and counter, N=5.
        low_to_en = 1'b1; low_reload = W'(100); low_terminal = W'(104);
        cyc(4);
        scl_in = 1'b0;
        for (int i = 1; i <= 7; i++) begin
            cyc(1);
            chk(low_to_pulse == (i == 7), "R1", int'(low_to_pulse), int'(i == 7));
        end
        scl_in = 1'b1; cyc(4);

        // R2: a short high gap restarts the count.
        pulse_cnt = 0;
        scl_in = 1'b0; cyc(4); scl_in = 1'b1; cyc(1); scl_in = 1'b0; cyc(4);
        scl_in = 1'b1; cyc(5);
        chk(pulse_cnt == 0, "R2", pulse_cnt, 0);

        // R3: terminal equals reload gives a pulse every low cycle.
        run_low(1, 6, 1'b1);
        // R4: disabled timer stays quiet.
        run_low(3, 30, 1'b0);

        for (int k = 0; k < 30; k++)
            run_low($urandom_range(1, 12), $urandom_range(0, 50),
                    ($urandom_range(0, 9) != 0));
        low_to_en = 1'b0;

        // R5: threshold at 10 versus 11 ticks.
        run_free(10, 1'b1, 0);
        run_free(11, 1'b1, 0);
        // R8: disabled detector.
        run_free(20, 1'b0, 0);

        // R6: once per idle interval.
        free_to_en = 1'b1; cyc(4);
        tick_n(11); cyc(1);
        chk(stop_flag == 1'b1, "R6", int'(stop_flag), 1);
        stop_clr = 1'b1; cyc(1); stop_clr = 1'b0;
        tick_n(15); cyc(1);
        chk(stop_flag == 1'b0, "R6", int'(stop_flag), 0);
        scl_in = 1'b0; cyc(4); scl_in = 1'b1; cyc(4);

        // R7: a low SDA pulse splits the count.
        tick_n(6);
        sda_in = 1'b0; cyc(4); tick_n(2); sda_in = 1'b1; cyc(4);
        tick_n(6); cyc(1);
        chk(stop_flag == 1'b0, "R7", int'(stop_flag), 0);
        tick_n(5); cyc(1);
        chk(stop_flag == 1'b1, "R7", int'(stop_flag), 1);
        stop_clr = 1'b1; cyc(1); stop_clr = 1'b0;
        scl_in = 1'b0; cyc(4); scl_in = 1'b1; cyc(4);

        // R9: set wins over a clear in the same cycle.
        tick_n(10);
        src_tick = 1'b1; stop_clr = 1'b1; cyc(1);
        src_tick = 1'b0; stop_clr = 1'b0; cyc(1);
        chk(stop_flag == 1'b1, "R9", int'(stop_flag), 1);
        chk(irq == 1'b1, "R10", int'(irq), 1);
        stop_clr = 1'b1; cyc(1); stop_clr = 1'b0; cyc(1);
        chk(stop_flag == 1'b0 && irq == 1'b0, "R9", int'(stop_flag), 0);
        scl_in = 1'b0; cyc(4); scl_in = 1'b1;

        for (int k = 0; k < 30; k++)
            run_free($urandom_range(0, 16), ($urandom_range(0, 3) != 0),
                     $urandom_range(0, 2));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule